// File: doc/BRIEF.md
# Codebook Codeword Select, Update and Replace Unit

This unit is the write-back stage of a per-pixel multi-codeword background model. For each pixel it takes the matching result of up to five codeword comparators, the codeword records themselves, the pixel colour and its brightness, and the current frame time. It returns the rewritten codebook and a foreground flag. The input and output codebooks have the same format, so the output can go straight back to the model store.

If one or more eligible codewords match, the unit picks the one with the highest use count. It then moves that codeword's mean colour toward the pixel, widens its brightness range, and updates its count, its longest idle run and its last-access time. If nothing matches, the unit writes a new codeword into a free slot. When every slot is in use, the new codeword replaces the slot that was accessed least recently.

A mode input chooses between building the model and running detection. The mode controls which layer may be matched and which layer receives new codewords. The unit is a four-stage pipeline and accepts one pixel per clock.

Top module: `cw_update`

## Requirements
- R1: A pixel presented with `valid_i` high appears on the outputs with `valid_o` high exactly four clock cycles later. A new pixel can be accepted every cycle, and results leave in input order.
- R2: Match bit k counts only when slot k has its valid bit set (1) and, in build mode (`mode_i`=0), the slot is in the background layer (layer bit 0). In detect mode (`mode_i`=1) slots in both layers, background (0) and cache (1), are eligible.
- R3: When several eligible codewords match, the one with the largest count `freq` is updated. On a tie, the lowest slot index wins.
- R4: The mean of each channel is stored with 5 fraction bits and updates as mean + ((pixel·32 − mean) >>> k), using an arithmetic shift that rounds toward minus infinity. 2^k is the power of two nearest to the incremented count, and an exact midpoint picks the larger power.
- R5: On a match, the unit applies these changes:
  - the low brightness bound becomes min(low, I) and the high bound becomes max(high, I);
  - `freq` increases by one and saturates at its maximum;
  - `run` becomes max(run, t − last), computed modulo the time width;
  - `last` becomes t.
  - `first`, `layer` and `vld` keep their values.
- R6: When nothing matches, a new codeword is written with these fields:
  - `vld`=1 and `layer` equal to `mode_i`;
  - mean equal to the pixel value times 32;
  - both brightness bounds equal to I;
  - `freq`=1, `run`=t−1, `first`=`last`=t.
- R7: The slot for a new codeword is the lowest-index slot whose valid bit is 0. If there is none, it is the slot with the smallest `last` (unsigned), and on a tie the lowest index.
- R8: `fg_o` is 1 when no eligible background-layer codeword matched, and 0 otherwise.
- R9: Every slot other than the one written leaves the unit unchanged.
- R10: While reset is active and after reset until the first result, `valid_o` is 0.

Record layout, from MSB to LSB, for each 129-bit slot k at bits [k·129 +: 129]:

| Field | Width | Format |
|---|---|---|
| `vld` | 1 | |
| `layer` | 1 | |
| `mr`, `mg`, `mb` | 13 each | 8.5 fixed point |
| `bmin`, `bmax` | 12 each | |
| `freq` | 16 | |
| `run` | 16 | |
| `first` | 16 | |
| `last` | 16 | |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Pixel and codebook inputs are valid |
| mode_i | input | 1 | 0 = build, 1 = detect |
| match_i | input | N_CW | Per-slot match result from the comparators |
| red_i | input | 8 | Pixel red |
| grn_i | input | 8 | Pixel green |
| blu_i | input | 8 | Pixel blue |
| bri_i | input | 12 | Pixel brightness |
| time_i | input | 16 | Current frame time |
| cb_i | input | N_CW·129 | Codebook in |
| valid_o | output | 1 | Result valid |
| fg_o | output | 1 | Foreground flag |
| cb_o | output | N_CW·129 | Codebook out |

## Verification
The bench checks these corner cases:
- **Tied counts and ignored match bits.** With tied counts, a design that picks the wrong slot rewrites the wrong codeword. The bench also sends matches on cache-layer or invalid slots in build mode; a design that honours them updates a stale record instead of creating a new one.
- **Count midpoints.** Counts such as 3 and 6 sit exactly between two powers of two. Rounding the wrong way changes the mean by one shift step. The bench drives pixels both above and below the mean, so a logical shift in place of the arithmetic shift produces a large wrong mean.
- **Saturating count, idle run and replacement.** A count at its maximum must hold rather than wrap. A new gap longer than the stored run must replace it. A full codebook with a tie on `last`, or one with a hole in the middle, must pick the victim described in R7.
- **Foreground in detect mode.** When only the cache layer matches, the pixel must be flagged foreground.

// File: rtl/cw_pkg.sv
package cw_pkg;
  parameter int unsigned CH_W   = 8;
  parameter int unsigned FRAC_W = 5;
  parameter int unsigned BR_W   = 12;
  parameter int unsigned FREQ_W = 16;
  parameter int unsigned TIME_W = 16;
  localparam int unsigned MEAN_W = CH_W + FRAC_W;

  typedef struct packed {
    logic              vld;
    logic              layer;   // 0 background, 1 cache
    logic [MEAN_W-1:0] mr;
    logic [MEAN_W-1:0] mg;
    logic [MEAN_W-1:0] mb;
    logic [BR_W-1:0]   bmin;
    logic [BR_W-1:0]   bmax;
    logic [FREQ_W-1:0] freq;
    logic [TIME_W-1:0] run;
    logic [TIME_W-1:0] first;
    logic [TIME_W-1:0] last;
  } cw_t;

  localparam int unsigned CW_W = $bits(cw_t);

  typedef enum logic {MODE_BUILD = 1'b0, MODE_DETECT = 1'b1} mode_e;
endpackage

// File: rtl/cw_select.sv
module cw_select
  import cw_pkg::*;
#(
  parameter int unsigned N_CW  = 5,
  parameter int unsigned IDX_W = 3
) (
  input  cw_t [N_CW-1:0]  cb_i,
  input  logic [N_CW-1:0] match_i,
  input  logic            mode_i,
  output logic            hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic            fg_o
);
  logic [N_CW-1:0]   elig;
  logic              bg_hit, free_found;
  logic [IDX_W-1:0]  best_idx, free_idx, old_idx;
  logic [FREQ_W-1:0] best_f;
  logic [TIME_W-1:0] old_t;

  always_comb begin
    bg_hit = 1'b0;
    for (int i = 0; i < N_CW; i++) begin
      elig[i] = match_i[i] & cb_i[i].vld & ((mode_i == MODE_DETECT) | ~cb_i[i].layer);
      if (elig[i] && !cb_i[i].layer) bg_hit = 1'b1;
    end
  end

  // highest count wins, strict compare keeps the lowest index on ties
  always_comb begin
    hit_o    = 1'b0;
    best_idx = '0;
    best_f   = '0;
    for (int i = 0; i < N_CW; i++) begin
      if (elig[i] && (!hit_o || cb_i[i].freq > best_f)) begin
        hit_o    = 1'b1;
        best_idx = IDX_W'(i);
        best_f   = cb_i[i].freq;
      end
    end
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    old_idx    = '0;
    old_t      = cb_i[0].last;
    for (int i = 0; i < N_CW; i++) begin
      if (!cb_i[i].vld && !free_found) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    for (int i = 1; i < N_CW; i++) begin
      if (cb_i[i].last < old_t) begin
        old_t   = cb_i[i].last;
        old_idx = IDX_W'(i);
      end
    end
  end

  assign idx_o = hit_o ? best_idx : (free_found ? free_idx : old_idx);
  assign fg_o  = ~bg_hit;
endmodule

// File: rtl/cw_calc.sv
module cw_calc
  import cw_pkg::*;
(
  input  cw_t               rec_i,
  input  logic              hit_i,
  input  logic              mode_i,
  input  logic [CH_W-1:0]   red_i,
  input  logic [CH_W-1:0]   grn_i,
  input  logic [CH_W-1:0]   blu_i,
  input  logic [BR_W-1:0]   bri_i,
  input  logic [TIME_W-1:0] time_i,
  output cw_t               rec_o
);
  localparam int unsigned SH_W = $clog2(FREQ_W + 1);

  logic [FREQ_W-1:0] f_nxt;
  logic [SH_W-1:0]   sh;
  logic [TIME_W-1:0] gap;
  int                msb;

  function automatic logic [MEAN_W-1:0] blend(input logic [MEAN_W-1:0] m,
                                               input logic [CH_W-1:0] x,
                                               input logic [SH_W-1:0] k);
    logic signed [MEAN_W:0] d;
    logic signed [MEAN_W:0] s;
    d = $signed({1'b0, x, {FRAC_W{1'b0}}}) - $signed({1'b0, m});
    s = d >>> k;
    return m + s[MEAN_W-1:0];
  endfunction

  // shift = log2 of the power of two nearest the new count, midpoint rounds up
  always_comb begin
    f_nxt = (&rec_i.freq) ? rec_i.freq : rec_i.freq + 1'b1;
    msb   = 0;
    for (int b = 0; b < FREQ_W; b++) if (f_nxt[b]) msb = b;
    sh = SH_W'(msb);
    if (msb > 0) begin
      if (f_nxt[msb-1]) sh = SH_W'(msb + 1);
    end
  end

  assign gap = time_i - rec_i.last;

  always_comb begin
    if (hit_i) begin
      rec_o      = rec_i;
      rec_o.mr   = blend(rec_i.mr, red_i, sh);
      rec_o.mg   = blend(rec_i.mg, grn_i, sh);
      rec_o.mb   = blend(rec_i.mb, blu_i, sh);
      rec_o.bmin = (bri_i < rec_i.bmin) ? bri_i : rec_i.bmin;
      rec_o.bmax = (bri_i > rec_i.bmax) ? bri_i : rec_i.bmax;
      rec_o.freq = f_nxt;
      rec_o.run  = (gap > rec_i.run) ? gap : rec_i.run;
      rec_o.last = time_i;
    end else begin
      rec_o.vld   = 1'b1;
      rec_o.layer = mode_i;
      rec_o.mr    = {red_i, {FRAC_W{1'b0}}};
      rec_o.mg    = {grn_i, {FRAC_W{1'b0}}};
      rec_o.mb    = {blu_i, {FRAC_W{1'b0}}};
      rec_o.bmin  = bri_i;
      rec_o.bmax  = bri_i;
      rec_o.freq  = FREQ_W'(1);
      rec_o.run   = time_i - 1'b1;
      rec_o.first = time_i;
      rec_o.last  = time_i;
    end
  end
endmodule

// File: rtl/cw_update.sv
module cw_update
  import cw_pkg::*;
#(
  parameter int unsigned N_CW = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 mode_i,
  input  logic [N_CW-1:0]      match_i,
  input  logic [CH_W-1:0]      red_i,
  input  logic [CH_W-1:0]      grn_i,
  input  logic [CH_W-1:0]      blu_i,
  input  logic [BR_W-1:0]      bri_i,
  input  logic [TIME_W-1:0]    time_i,
  input  logic [N_CW*CW_W-1:0] cb_i,
  output logic                 valid_o,
  output logic                 fg_o,
  output logic [N_CW*CW_W-1:0] cb_o
);
  localparam int unsigned IDX_W = (N_CW > 1) ? $clog2(N_CW) : 1;

  // stage 1: capture
  logic              s1_vld, s1_mode;
  logic [N_CW-1:0]   s1_match;
  logic [CH_W-1:0]   s1_r, s1_g, s1_b;
  logic [BR_W-1:0]   s1_bri;
  logic [TIME_W-1:0] s1_t;
  cw_t [N_CW-1:0]    s1_cb;
  // stage 2: selection
  logic              s2_vld, s2_mode, s2_hit, s2_fg;
  logic [N_CW-1:0]   s2_match;
  logic [CH_W-1:0]   s2_r, s2_g, s2_b;
  logic [BR_W-1:0]   s2_bri;
  logic [TIME_W-1:0] s2_t;
  cw_t [N_CW-1:0]    s2_cb;
  logic [IDX_W-1:0]  s2_idx;
  // stage 3: new record
  logic              s3_vld, s3_hit, s3_fg;
  cw_t [N_CW-1:0]    s3_cb;
  logic [IDX_W-1:0]  s3_idx;
  cw_t               s3_rec;
  // stage 4: write back
  cw_t [N_CW-1:0]    out_cb, nxt_cb;
  logic [IDX_W-1:0]  out_idx;

  logic              sel_hit, sel_fg;
  logic [IDX_W-1:0]  sel_idx;
  cw_t               calc_rec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0; s1_mode <= 1'b0; s1_match <= '0;
      s1_r <= '0; s1_g <= '0; s1_b <= '0; s1_bri <= '0; s1_t <= '0; s1_cb <= '0;
    end else begin
      s1_vld <= valid_i; s1_mode <= mode_i; s1_match <= match_i;
      s1_r <= red_i; s1_g <= grn_i; s1_b <= blu_i; s1_bri <= bri_i; s1_t <= time_i;
      s1_cb <= cb_i;
    end
  end

  cw_select #(.N_CW(N_CW), .IDX_W(IDX_W)) i_select (
    .cb_i(s1_cb), .match_i(s1_match), .mode_i(s1_mode),
    .hit_o(sel_hit), .idx_o(sel_idx), .fg_o(sel_fg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0; s2_mode <= 1'b0; s2_hit <= 1'b0; s2_fg <= 1'b0; s2_match <= '0;
      s2_r <= '0; s2_g <= '0; s2_b <= '0; s2_bri <= '0; s2_t <= '0; s2_cb <= '0;
      s2_idx <= '0;
    end else begin
      s2_vld <= s1_vld; s2_mode <= s1_mode; s2_hit <= sel_hit; s2_fg <= sel_fg;
      s2_match <= s1_match;
      s2_r <= s1_r; s2_g <= s1_g; s2_b <= s1_b; s2_bri <= s1_bri; s2_t <= s1_t;
      s2_cb <= s1_cb; s2_idx <= sel_idx;
    end
  end

  cw_calc i_calc (
    .rec_i(s2_cb[s2_idx]), .hit_i(s2_hit), .mode_i(s2_mode),
    .red_i(s2_r), .grn_i(s2_g), .blu_i(s2_b), .bri_i(s2_bri), .time_i(s2_t),
    .rec_o(calc_rec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_vld <= 1'b0; s3_hit <= 1'b0; s3_fg <= 1'b0; s3_cb <= '0; s3_idx <= '0;
      s3_rec <= '0;
    end else begin
      s3_vld <= s2_vld; s3_hit <= s2_hit; s3_fg <= s2_fg; s3_cb <= s2_cb;
      s3_idx <= s2_idx; s3_rec <= calc_rec;
    end
  end

  always_comb begin
    nxt_cb         = s3_cb;
    nxt_cb[s3_idx] = s3_rec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; fg_o <= 1'b0; out_cb <= '0; out_idx <= '0;
    end else begin
      valid_o <= s3_vld; fg_o <= s3_fg; out_cb <= nxt_cb; out_idx <= s3_idx;
    end
  end

  assign cb_o = out_cb;

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 4));

  p_sel_eligible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld && s2_hit |-> s2_match[s2_idx] && s2_cb[s2_idx].vld);

  p_run_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_vld && s3_hit |-> s3_rec.run >= $past(s2_cb[s2_idx].run) && s3_rec.last == $past(s2_t));

  p_new_init_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_vld && !s3_hit |-> s3_rec.vld && s3_rec.freq == FREQ_W'(1) && s3_rec.first == s3_rec.last);

  p_written_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> out_cb[out_idx].vld);

  p_bg_implies_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_vld && !s2_fg |-> s2_hit);
endmodule

// File: tb/test_cw_update.sv
module test_cw_update;
  import cw_pkg::*;
  localparam int unsigned N = 5;
  typedef cw_t [N-1:0] book_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, mode_i = 1'b0;
  logic [N-1:0] match_i = '0;
  logic [CH_W-1:0] red_i = '0, grn_i = '0, blu_i = '0;
  logic [BR_W-1:0] bri_i = '0;
  logic [TIME_W-1:0] time_i = '0;
  book_t cb_in = '0;
  logic valid_o, fg_o;
  logic [N*CW_W-1:0] cb_o;

  int tests = 0, fails = 0;
  book_t exp_cb_q[$];
  logic  exp_fg_q[$];
  string exp_tag_q[$];

  always #2 clk_i = ~clk_i;

  cw_update #(.N_CW(N)) i_cw_update (
    .clk_i, .rst_ni, .valid_i, .mode_i, .match_i, .red_i, .grn_i, .blu_i,
    .bri_i, .time_i, .cb_i(cb_in), .valid_o, .fg_o, .cb_o
  );

  function automatic cw_t mk(logic v, logic ly, int r, int g, int b, int lo, int hi,
                             int f, int rn, int fi, int la);
    cw_t c;
    c.vld = v; c.layer = ly;
    c.mr = MEAN_W'(r); c.mg = MEAN_W'(g); c.mb = MEAN_W'(b);
    c.bmin = BR_W'(lo); c.bmax = BR_W'(hi); c.freq = FREQ_W'(f);
    c.run = TIME_W'(rn); c.first = TIME_W'(fi); c.last = TIME_W'(la);
    return c;
  endfunction

  function automatic logic [MEAN_W-1:0] avg(logic [MEAN_W-1:0] m, logic [7:0] x, int k);
    longint d;
    d = (longint'(x) * 32) - longint'(m);
    d = d >>> k;
    return MEAN_W'(longint'(m) + d);
  endfunction

  function automatic void model(logic mode, logic [N-1:0] m, logic [7:0] r, logic [7:0] g,
                                logic [7:0] b, logic [BR_W-1:0] br, logic [TIME_W-1:0] t,
                                book_t cb, output book_t ob, output logic fg);
    int best, tgt, k;
    longint fn, bestdist;
    logic [TIME_W-1:0] gap;
    ob = cb; best = -1; fg = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (m[i] && cb[i].vld && (mode || !cb[i].layer)) begin
        if (!cb[i].layer) fg = 1'b0;
        if (best < 0 || cb[i].freq > cb[best].freq) best = i;
      end
    end
    if (best >= 0) begin
      fn = (cb[best].freq == '1) ? longint'(cb[best].freq) : longint'(cb[best].freq) + 1;
      k = 0; bestdist = -1;
      for (int j = 0; j <= FREQ_W; j++) begin
        longint p2, dd;
        p2 = longint'(1) << j;
        dd = (p2 > fn) ? p2 - fn : fn - p2;
        if (bestdist < 0 || dd <= bestdist) begin bestdist = dd; k = j; end
      end
      ob[best].mr = avg(cb[best].mr, r, k);
      ob[best].mg = avg(cb[best].mg, g, k);
      ob[best].mb = avg(cb[best].mb, b, k);
      if (br < cb[best].bmin) ob[best].bmin = br;
      if (br > cb[best].bmax) ob[best].bmax = br;
      ob[best].freq = FREQ_W'(fn);
      gap = t - cb[best].last;
      if (gap > cb[best].run) ob[best].run = gap;
      ob[best].last = t;
    end else begin
      tgt = -1;
      for (int i = 0; i < N; i++) if (tgt < 0 && !cb[i].vld) tgt = i;
      if (tgt < 0) begin
        tgt = 0;
        for (int i = 1; i < N; i++) if (cb[i].last < cb[tgt].last) tgt = i;
      end
      ob[tgt] = mk(1'b1, mode, int'(r) * 32, int'(g) * 32, int'(b) * 32, int'(br), int'(br),
                   1, int'(t) - 1, int'(t), int'(t));
    end
  endfunction

  task automatic send(logic mode, logic [N-1:0] m, int r, int g, int b, int br, int t,
                      book_t cb, string tag);
    book_t eb;
    logic efg;
    model(mode, m, 8'(r), 8'(g), 8'(b), BR_W'(br), TIME_W'(t), cb, eb, efg);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = mode; match_i = m;
    red_i = 8'(r); grn_i = 8'(g); blu_i = 8'(b); bri_i = BR_W'(br); time_i = TIME_W'(t);
    cb_in = cb;
    exp_cb_q.push_back(eb); exp_fg_q.push_back(efg); exp_tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; match_i = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_cb_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R1 unexpected result: actual valid_o=1 expected 0");
      end else begin
        book_t eb;
        logic efg;
        string tg;
        eb = exp_cb_q.pop_front(); efg = exp_fg_q.pop_front(); tg = exp_tag_q.pop_front();
        tests++;
        if (cb_o !== eb) begin
          fails++;
          $display("FAIL %s codebook: actual %h expected %h", tg, cb_o, eb);
        end
        tests++;
        if (fg_o !== efg) begin
          fails++;
          $display("FAIL %s/R8 fg: actual %0b expected %0b", tg, fg_o, efg);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    book_t cb;
    repeat (3) @(posedge clk_i);
    #1;
    tests++;
    if (valid_o !== 1'b0) begin fails++; $display("FAIL R10 reset valid_o: actual %0b expected 0", valid_o); end
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2);
    tests++;
    if (valid_o !== 1'b0) begin fails++; $display("FAIL R10 idle valid_o: actual %0b expected 0", valid_o); end

    // R6: empty book, build mode
    send(1'b0, '0, 10, 20, 30, 400, 10, '0, "R6_empty");
    // R3: highest count, then tie to lowest index
    cb = '0;
    cb[0] = mk(1, 0, 3200, 3200, 3200, 100, 200, 3, 0, 1, 5);
    cb[1] = mk(1, 0, 1600, 1600, 1600, 100, 200, 7, 1, 1, 6);
    send(1'b0, 5'b00011, 60, 60, 60, 150, 20, cb, "R3_maxf");
    cb[2] = mk(1, 0, 960, 960, 960, 50, 90, 3, 2, 1, 7);
    cb[1].freq = 3;
    send(1'b0, 5'b00111, 70, 10, 200, 80, 21, cb, "R3_tie");
    // R4: midpoints 3 and 6, both directions
    cb = '0;
    cb[0] = mk(1, 0, 3200, 100, 5000, 100, 200, 2, 0, 1, 4);
    send(1'b0, 5'b00001, 40, 250, 0, 150, 9, cb, "R4_f3");
    cb[0].freq = 5;
    send(1'b0, 5'b00001, 255, 0, 160, 150, 9, cb, "R4_f6");
    cb[0].freq = 11;
    send(1'b0, 5'b00001, 1, 2, 3, 150, 9, cb, "R4_f12");
    // R5: saturation, run growth, brightness bounds
    cb = '0;
    cb[1] = mk(1, 0, 100, 100, 100, 300, 500, 16'hFFFF, 2, 0, 5);
    send(1'b0, 5'b00010, 9, 9, 9, 100, 50, cb, "R5_sat_run");
    cb[1] = mk(1, 0, 100, 100, 100, 300, 500, 8, 100, 0, 47);
    send(1'b0, 5'b00010, 9, 9, 9, 900, 50, cb, "R5_keep_run");
    // R2: build mode ignores cache and invalid slots
    cb = '0;
    cb[0] = mk(1, 1, 100, 100, 100, 10, 20, 9, 0, 0, 3);
    send(1'b0, 5'b00011, 5, 6, 7, 15, 30, cb, "R2_cache_ignored");
    send(1'b1, 5'b00011, 5, 6, 7, 15, 30, cb, "R2_detect_cache");
    // R7: victim choice
    for (int i = 0; i < N; i++) cb[i] = mk(1, 0, 64, 64, 64, 1, 2, 4, 0, 0, 30 + i * 5);
    cb[1].last = 12; cb[3].last = 12;
    send(1'b0, '0, 1, 2, 3, 4, 60, cb, "R7_lru_tie");
    cb[3].vld = 1'b0;
    send(1'b0, '0, 1, 2, 3, 4, 60, cb, "R7_hole");
    // R8: detect mode foreground
    cb = '0;
    cb[0] = mk(1, 0, 100, 100, 100, 10, 20, 2, 0, 0, 3);
    cb[2] = mk(1, 1, 300, 300, 300, 10, 20, 9, 0, 0, 4);
    send(1'b1, 5'b00100, 9, 9, 9, 15, 40, cb, "R8_cache_only");
    send(1'b1, 5'b00101, 9, 9, 9, 15, 40, cb, "R8_bg_and_cache");
    for (int i = 0; i < N; i++) cb[i] = mk(1, i % 2, 64, 64, 64, 1, 2, 4, 0, 0, 90 - i);
    send(1'b1, '0, 1, 2, 3, 4, 99, cb, "R8_new_cache");
    // R1/R9: back-to-back random stream
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < N; i++)
        cb[i] = mk(($urandom % 5) != 0, $urandom % 2, $urandom % 8192, $urandom % 8192,
                   $urandom % 8192, $urandom % 2048, 2048 + $urandom % 2048,
                   $urandom % 70000, $urandom % 65536, $urandom % 65536, $urandom % 65536);
      send($urandom % 2, 5'($urandom), $urandom % 256, $urandom % 256, $urandom % 256,
           $urandom % 4096, $urandom % 65536, cb, "R9_random");
    end
    idle(12);
    tests++;
    if (exp_cb_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results: actual %0d pending expected 0", exp_cb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule